// File: doc/BRIEF.md
# ADC control and status register block

This block is the register and sequencing front end of an analog-to-digital converter controller. A simple bus port reads and writes one control/status word and reads one result register for each input channel. The control word holds a completion flag, an interrupt enable, a run bit, a scan-mode select and a channel field. When software sets the run bit, the sequencer sends a one-cycle start pulse and a channel index to the converter. It then waits for the converter's end-of-conversion pulse, captures the result, raises a DMA request and sets the completion flag.

In single mode one conversion is made on the chosen channel and the run bit then clears itself. In scan mode the channels are converted in ascending order and the sequence wraps around while the run bit stays set. If software clears the run bit during a scan, the sequence stops once the conversion in flight has finished. The completion flag can only be cleared by writing 0 after a read that returned 1. The rule is race-safe: a read that lands on the same cycle as a new completion sees the flag as 1. A module-standby input holds the whole block in its reset state for as long as it is asserted.

Top module: `adc_ctl_top`

## Requirements
- R1: After reset the control word (address 0) reads 0, every result register reads 0, and irq_o, dma_req_o and conv_start_o are low.
- R2: An end-of-conversion pulse accepted during a conversion writes conv_data_i into the result register of the converting channel k (address 1+k, bits [9:0]). dma_req_o is high for exactly one cycle, the cycle after the pulse, once per accepted result.
- R3: Control word layout: bit 7 completion flag, bit 6 interrupt enable, bit 5 run, bit 4 scan select, bits [1:0] channel. The flag reads 1 from the cycle after an accepted end-of-conversion. irq_o is high while the stored flag is 1 and bit 6 is 1, and low when bit 6 is 0.
- R4: A write of bit 7 = 0 clears the flag only if a read of the control word has returned bit 7 = 1 since the flag was last cleared. Without such a read the write has no effect. Writing bit 7 = 1 never sets the flag.
- R5: A read in the cycle that follows an accepted end-of-conversion returns bit 7 = 1 even if the stored flag is still 0. That read arms the clear, so the next write of bit 7 = 0 clears the flag.
- R6: When a clearing write lands on the same cycle as a new flag set, the flag stays 1 and the clear stays armed, so a later write of bit 7 = 0 clears it without another read.
- R7: In single mode (bit 4 = 0), setting bit 5 gives one start pulse with conv_chan_o equal to the channel field. Bit 5 then reads 0 after the end-of-conversion.
- R8: In scan mode (bit 4 = 1) the start pulses carry channels 0, 1, ..., NUM_CH-1, 0, ... in order, for as long as bit 5 stays 1.
- R9: Writing bit 5 = 0 during a scan lets the conversion in flight finish and deliver its result and DMA request, then issues no further start pulse.
- R10: While standby_i is high, irq_o, dma_req_o and conv_start_o stay low. After release the control word and all result registers read 0 and no conversion restarts.
- R11: An end-of-conversion pulse while no conversion is in progress changes no result register, raises no DMA request and leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | Module standby; holds the block in reset while high |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address: 0 control word, 1+k result of channel k |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the access cycle |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_chan_o | output | $clog2(NUM_CH) | Channel under conversion, held until end-of-conversion |
| conv_eoc_i | input | 1 | End-of-conversion pulse from the converter |
| conv_data_i | input | RES_W | Conversion result, valid with conv_eoc_i |
| irq_o | output | 1 | Completion interrupt |
| dma_req_o | output | 1 | One-cycle DMA request per accepted result |

## Verification
A wrong clear-arming state shows up one cycle after the clearing write. Either irq_o stays high when it should drop, or the flag is still set on the next read. A channel pointer that steps wrongly shows on conv_chan_o at the very next start pulse. A sequencer that accepts end-of-conversion outside a conversion gives an extra dma_req_o pulse one cycle after the stray pulse. A missed stop in scan mode gives a further start pulse a few cycles after the in-flight result.

// File: rtl/adc_ctl_pkg.sv
`timescale 1ns/1ps
// Package: adc_ctl_pkg
// Shared constants and types for the ADC control and status block.
// Assumes a control word of at least 8 bits and at most 16 channels.
package adc_ctl_pkg;

    // Register addresses
    localparam int CSR_ADDR = 0;
    localparam int RES_BASE = 1;

    // Control word bit positions (software visible)
    localparam int BIT_DONE = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_RUN  = 5;
    localparam int BIT_SCAN = 4;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_done_flag.sv
`timescale 1ns/1ps
// Module: adc_done_flag
// Holds the completion flag and its read-before-clear arming state.
// A registered set-pending stage follows each accepted end-of-conversion.
// It drives the DMA request and makes a racing read see the flag as 1.
// Assumes csr_rd_i and csr_clr_i are never high in the same cycle.
module adc_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic accept_i,
    input  logic csr_rd_i,
    input  logic csr_clr_i,
    output logic done_o,
    output logic done_vis_o,
    output logic set_pend_o
);

    logic srst;
    logic set_pend_q;
    logic done_q;
    logic armed_q;

    // Combined reset: power-on reset or module standby
    assign srst = !rst_n || standby_i;

    // Set-pending stage: one cycle after an accepted result
    always_ff @(posedge clk) begin
        if (srst) begin
            set_pend_q <= 1'b0;
        end else begin
            set_pend_q <= accept_i;
        end
    end

    // Flag and arming update; a set beats a simultaneous clear
    always_ff @(posedge clk) begin
        if (srst) begin
            done_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_pend_q) begin
            done_q  <= 1'b1;
            armed_q <= armed_q || csr_rd_i;
        end else if (csr_clr_i && armed_q) begin
            done_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (csr_rd_i && done_q) begin
            armed_q <= 1'b1;
        end
    end

    assign done_o     = done_q;
    assign done_vis_o = done_q || set_pend_q;
    assign set_pend_o = set_pend_q;

    // The flag may only fall by an armed clearing write or by reset
    AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (srst)
        $fell(done_q) |-> (($past(armed_q) && $past(csr_clr_i)) || $past(srst))); // R4

    // A pending set always lands in the flag, whatever write came with it
    AST_SET_WINS: assert property (@(posedge clk) disable iff (srst)
        set_pend_q |=> done_q); // R6

    // A read racing the set leaves the clear armed
    AST_RACE_ARMS: assert property (@(posedge clk) disable iff (srst)
        (set_pend_q && csr_rd_i) |=> armed_q); // R5

endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
// Module: adc_scan_seq
// Owns the run bit and the conversion sequencer. From idle with run set it
// sends a start pulse, waits for end-of-conversion, and then stops (single
// mode, run self-clears) or steps to the next channel (scan mode).
// Assumes the converter sends one end-of-conversion per start pulse.
module adc_scan_seq
    import adc_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            standby_i,
    input  logic            run_wr_i,
    input  logic            run_wdata_i,
    input  logic            scan_i,
    input  logic [CH_W-1:0] chan_sel_i,
    input  logic            conv_eoc_i,
    output logic            run_o,
    output logic            conv_start_o,
    output logic [CH_W-1:0] conv_chan_o,
    output logic            accept_o
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic            srst;
    logic            run_q;
    seq_state_e      state_q;
    logic [CH_W-1:0] cur_chan_q;
    logic [CH_W-1:0] next_chan;

    // Combined reset: power-on reset or module standby
    assign srst = !rst_n || standby_i;

    // Result accepted only while waiting on the converter
    assign accept_o = (state_q == SEQ_WAIT) && conv_eoc_i;

    // Ascending channel step with wrap at the last channel
    assign next_chan = (cur_chan_q == LAST_CH) ? '0 : cur_chan_q + 1'b1;

    // Run bit: bus write first, else self-clear at end of a single conversion
    always_ff @(posedge clk) begin
        if (srst) begin
            run_q <= 1'b0;
        end else if (run_wr_i) begin
            run_q <= run_wdata_i;
        end else if (accept_o && !scan_i) begin
            run_q <= 1'b0;
        end
    end

    // Sequencer state and channel pointer
    always_ff @(posedge clk) begin
        if (srst) begin
            state_q    <= SEQ_IDLE;
            cur_chan_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (run_q) begin
                        state_q    <= SEQ_START;
                        cur_chan_q <= scan_i ? '0 : chan_sel_i;
                    end
                end
                SEQ_START: begin
                    state_q <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (conv_eoc_i) begin
                        if (scan_i && run_q) begin
                            state_q    <= SEQ_START;
                            cur_chan_q <= next_chan;
                        end else begin
                            state_q <= SEQ_IDLE;
                        end
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign run_o        = run_q;
    assign conv_start_o = (state_q == SEQ_START);
    assign conv_chan_o  = cur_chan_q;

    // No start pulse without the run bit set the cycle before
    AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (srst)
        conv_start_o |-> $past(run_q)); // R7

    // Single mode: run clears after the result unless software rewrites it
    AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (srst)
        (accept_o && !scan_i && !run_wr_i) |=> !run_q); // R7

    // Scan mode: the next start carries the following channel
    AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (srst)
        (accept_o && scan_i && run_q) |=>
            (conv_start_o && (conv_chan_o ==
                (($past(cur_chan_q) == LAST_CH) ? '0 : $past(cur_chan_q) + 1'b1)))); // R8

    // Run low at the end of a conversion means no further start
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (srst)
        (accept_o && !run_q) |=> !conv_start_o); // R9

endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/1ps
// Module: adc_result_bank
// One result register per channel, written on an accepted end-of-conversion
// and read through a channel-indexed mux.
// Assumes rd_chan_i is only used by the caller when it is below NUM_CH.
module adc_result_bank #(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 10,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic             wr_i,
    input  logic [CH_W-1:0]  wr_chan_i,
    input  logic [RES_W-1:0] wdata_i,
    input  logic [CH_W-1:0]  rd_chan_i,
    output logic [RES_W-1:0] rdata_o
);

    logic             srst;
    logic [RES_W-1:0] res_q [NUM_CH];

    // Combined reset: power-on reset or module standby
    assign srst = !rst_n || standby_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        // Capture the converter result for this channel
        always_ff @(posedge clk) begin
            if (srst) begin
                res_q[g] <= '0;
            end else if (wr_i && (wr_chan_i == CH_W'(g))) begin
                res_q[g] <= wdata_i;
            end
        end
    end

    // Read mux by channel index
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_chan_i == CH_W'(i)) begin
                rdata_o = res_q[i];
            end
        end
    end

endmodule

// File: rtl/adc_ctl_top.sv
`timescale 1ns/1ps
// Module: adc_ctl_top
// ADC control and status block: bus decode, control fields, completion
// flag, sequencer and result bank. Bus reads return data combinationally in
// the access cycle; every access lasts one cycle.
// Assumes DATA_W >= 8, DATA_W >= RES_W and NUM_CH <= 16.
module adc_ctl_top
    import adc_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 10,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        standby_i,
    input  logic                                        bus_sel_i,
    input  logic                                        bus_wr_i,
    input  logic [ADDR_W-1:0]                           bus_addr_i,
    input  logic [DATA_W-1:0]                           bus_wdata_i,
    output logic [DATA_W-1:0]                           bus_rdata_o,
    output logic                                        conv_start_o,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] conv_chan_o,
    input  logic                                        conv_eoc_i,
    input  logic [RES_W-1:0]                            conv_data_i,
    output logic                                        irq_o,
    output logic                                        dma_req_o
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [ADDR_W-1:0] A_CSR     = ADDR_W'(CSR_ADDR);
    localparam logic [ADDR_W-1:0] A_RES_LO  = ADDR_W'(RES_BASE);
    localparam logic [ADDR_W-1:0] A_RES_END = ADDR_W'(RES_BASE + NUM_CH);

    logic              srst;
    logic              addr_is_csr;
    logic              addr_is_res;
    logic              csr_rd;
    logic              csr_wr;
    logic              csr_clr;
    logic              ie_q;
    logic              scan_q;
    logic [CH_W-1:0]   chan_sel_q;
    logic              run;
    logic              accept;
    logic              done;
    logic              done_vis;
    logic              set_pend;
    logic [CH_W-1:0]   res_rd_chan;
    logic [RES_W-1:0]  res_rd_data;
    logic [DATA_W-1:0] csr_view;
    logic              wdata_unused;

    // Combined reset: power-on reset or module standby
    assign srst = !rst_n || standby_i;

    // Address decode and access strobes
    assign addr_is_csr = (bus_addr_i == A_CSR);
    assign addr_is_res = (bus_addr_i >= A_RES_LO) && (bus_addr_i < A_RES_END);
    assign csr_rd      = bus_sel_i && !bus_wr_i && addr_is_csr;
    assign csr_wr      = bus_sel_i && bus_wr_i && addr_is_csr;
    assign csr_clr     = csr_wr && !bus_wdata_i[BIT_DONE];
    assign res_rd_chan = CH_W'(bus_addr_i - A_RES_LO);
    assign wdata_unused = ^bus_wdata_i;

    // Software control fields: interrupt enable, scan select, channel
    always_ff @(posedge clk) begin
        if (srst) begin
            ie_q       <= 1'b0;
            scan_q     <= 1'b0;
            chan_sel_q <= '0;
        end else if (csr_wr) begin
            ie_q       <= bus_wdata_i[BIT_IE];
            scan_q     <= bus_wdata_i[BIT_SCAN];
            chan_sel_q <= bus_wdata_i[CH_W-1:0];
        end
    end

    adc_scan_seq #(
        .NUM_CH (NUM_CH)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby_i),
        .run_wr_i     (csr_wr),
        .run_wdata_i  (bus_wdata_i[BIT_RUN]),
        .scan_i       (scan_q),
        .chan_sel_i   (chan_sel_q),
        .conv_eoc_i   (conv_eoc_i),
        .run_o        (run),
        .conv_start_o (conv_start_o),
        .conv_chan_o  (conv_chan_o),
        .accept_o     (accept)
    );

    adc_done_flag i_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby_i),
        .accept_i   (accept),
        .csr_rd_i   (csr_rd),
        .csr_clr_i  (csr_clr),
        .done_o     (done),
        .done_vis_o (done_vis),
        .set_pend_o (set_pend)
    );

    adc_result_bank #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .wr_i      (accept),
        .wr_chan_i (conv_chan_o),
        .wdata_i   (conv_data_i),
        .rd_chan_i (res_rd_chan),
        .rdata_o   (res_rd_data)
    );

    // Assemble the control word view
    always_comb begin
        csr_view              = '0;
        csr_view[CH_W-1:0]    = chan_sel_q;
        csr_view[BIT_SCAN]    = scan_q;
        csr_view[BIT_RUN]     = run;
        csr_view[BIT_IE]      = ie_q;
        csr_view[BIT_DONE]    = done_vis;
    end

    // Read data mux
    always_comb begin
        bus_rdata_o = '0;
        if (addr_is_csr) begin
            bus_rdata_o = csr_view;
        end else if (addr_is_res) begin
            bus_rdata_o = DATA_W'(res_rd_data);
        end
    end

    assign irq_o     = done && ie_q;
    assign dma_req_o = set_pend;

    // A DMA request only follows an end-of-conversion pulse
    AST_DMA_AFTER_EOC: assert property (@(posedge clk) disable iff (srst)
        dma_req_o |-> $past(conv_eoc_i)); // R2

    // Held standby keeps every request output quiet
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_i && $past(standby_i)) |-> (!irq_o && !dma_req_o && !conv_start_o)); // R10

endmodule

// File: tb/test_adc_ctl_top.sv
`timescale 1ns/1ps
// Directed bench for adc_ctl_top with a behavioural converter model.
// All stimulus starts at a falling edge; outputs are sampled there.
module test_adc_ctl_top;

    localparam int NUM_CH = 4;
    localparam int RES_W  = 10;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int LAT    = 3;

    logic              clk;
    logic              rst_n;
    logic              standby;
    logic              bus_sel;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              conv_start;
    logic [1:0]        conv_chan;
    logic              conv_eoc;
    logic [RES_W-1:0]  conv_data;
    logic              irq;
    logic              dma_req;

    int errors = 0;
    int checks = 0;

    adc_ctl_top #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_adc_ctl_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby),
        .bus_sel_i    (bus_sel),
        .bus_wr_i     (bus_wr),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .conv_start_o (conv_start),
        .conv_chan_o  (conv_chan),
        .conv_eoc_i   (conv_eoc),
        .conv_data_i  (conv_data),
        .irq_o        (irq),
        .dma_req_o    (dma_req)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Converter model and output monitors
    int               starts = 0;
    int               chan_log [64];
    int               dma_cnt = 0;
    int               fires = 0;
    logic [RES_W-1:0] exp_res [NUM_CH];
    int               stray_req = 0;
    int               stray_done = 0;
    logic [RES_W-1:0] stray_val = '0;
    bit               m_busy = 1'b0;
    int               m_cnt = 0;
    int               m_chan = 0;

    initial begin
        conv_eoc  = 1'b0;
        conv_data = '0;
        for (int i = 0; i < NUM_CH; i++) exp_res[i] = '0;
    end

    always @(negedge clk) begin
        conv_eoc = 1'b0;
        if (dma_req) dma_cnt++;
        if (conv_start) begin
            if (starts < 64) chan_log[starts] = int'(conv_chan);
            starts++;
        end
        if (m_busy) begin
            if (m_cnt == 0) begin
                conv_eoc  = 1'b1;
                conv_data = RES_W'(m_chan * 100 + fires * 7 + 3);
                exp_res[m_chan] = conv_data;
                fires++;
                m_busy = 1'b0;
            end else begin
                m_cnt--;
            end
        end else if (conv_start) begin
            m_busy = 1'b1;
            m_cnt  = LAT;
            m_chan = int'(conv_chan);
        end else if (stray_done != stray_req) begin
            conv_eoc  = 1'b1;
            conv_data = stray_val;
            stray_done++;
        end
    end

    function automatic int csr(bit dn, bit ie, bit run, bit scan, int ch);
        return (int'(dn) << 7) | (int'(ie) << 6) | (int'(run) << 5) | (int'(scan) << 4) | ch;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Bus tasks: called at a falling edge, return at the next falling edge
    task automatic bus_write(int addr, int data);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = ADDR_W'(addr); bus_wdata = DATA_W'(data);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(int addr, output int data);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr);
        #1;
        data = int'(bus_rdata);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Returns at falling edge + 2 ns in the cycle that carries conv_eoc
    task automatic wait_fire();
        int f0 = fires;
        int n = 0;
        while (fires == f0 && n < 200) begin
            @(negedge clk); #2; n++;
        end
        if (fires == f0) chk("R2", "converter never finished", 0, 1);
    endtask

    task automatic t_reset();
        int v;
        chk("R1", "irq after reset", int'(irq), 0);
        chk("R1", "dma after reset", int'(dma_req), 0);
        chk("R1", "start after reset", int'(conv_start), 0);
        bus_read(0, v);
        chk("R1", "control word after reset", v, 0);
        for (int k = 0; k < NUM_CH; k++) begin
            bus_read(1 + k, v);
            chk("R1", "result after reset", v, 0);
        end
    endtask

    task automatic t_single();
        int v;
        int s0 = starts;
        int d0 = dma_cnt;
        bus_write(0, csr(1, 1, 1, 0, 2));
        wait_fire();
        idle(3);
        chk("R7", "single start count", starts - s0, 1);
        chk("R7", "single channel", chan_log[s0], 2);
        chk("R2", "single dma count", dma_cnt - d0, 1);
        bus_read(3, v);
        chk("R2", "single result ch2", v, int'(exp_res[2]));
        chk("R3", "irq with enable", int'(irq), 1);
        bus_read(0, v);
        chk("R7", "run self-cleared", (v >> 5) & 1, 0);
        chk("R3", "flag set", (v >> 7) & 1, 1);
        bus_write(0, csr(0, 1, 0, 0, 2));
        chk("R4", "irq after armed clear", int'(irq), 0);
        bus_read(0, v);
        chk("R4", "flag after armed clear", (v >> 7) & 1, 0);
    endtask

    task automatic t_no_read_clear();
        int v;
        bus_write(0, csr(1, 0, 1, 0, 1));
        wait_fire();
        idle(3);
        chk("R3", "irq with enable off", int'(irq), 0);
        bus_write(0, csr(0, 0, 0, 0, 1));
        bus_read(0, v);
        chk("R4", "clear without read ignored", (v >> 7) & 1, 1);
        bus_write(0, csr(0, 0, 0, 0, 1));
        bus_read(0, v);
        chk("R4", "clear after read", (v >> 7) & 1, 0);
        bus_write(0, csr(1, 0, 0, 0, 1));
        bus_read(0, v);
        chk("R4", "writing 1 does not set", (v >> 7) & 1, 0);
    endtask

    task automatic t_race();
        int v;
        bus_write(0, csr(1, 0, 1, 0, 0));
        wait_fire();
        @(negedge clk);
        bus_read(0, v);
        chk("R5", "racing read sees flag", (v >> 7) & 1, 1);
        bus_write(0, csr(0, 0, 0, 0, 0));
        bus_read(0, v);
        chk("R5", "clear armed by racing read", (v >> 7) & 1, 0);
    endtask

    task automatic t_priority();
        int v;
        bus_write(0, csr(1, 1, 1, 0, 3));
        wait_fire();
        idle(2);
        bus_read(0, v);
        chk("R6", "flag before second conversion", (v >> 7) & 1, 1);
        bus_write(0, csr(1, 1, 1, 0, 3));
        wait_fire();
        @(negedge clk);
        bus_write(0, csr(0, 1, 0, 0, 3));
        chk("R6", "set wins over clear", int'(irq), 1);
        bus_write(0, csr(0, 1, 0, 0, 3));
        chk("R6", "re-armed clear drops irq", int'(irq), 0);
        bus_read(0, v);
        chk("R6", "flag after re-armed clear", (v >> 7) & 1, 0);
    endtask

    task automatic t_scan();
        int v;
        int s0 = starts;
        int d0 = dma_cnt;
        int f0 = fires;
        int n = 0;
        bus_write(0, csr(1, 0, 1, 1, 0));
        while (starts - s0 < 6 && n < 500) begin
            @(negedge clk); #2; n++;
        end
        @(negedge clk);
        bus_write(0, csr(1, 0, 0, 1, 0));
        idle(40);
        chk("R9", "starts after stop", starts - s0, 6);
        for (int k = 0; k < 6; k++) begin
            chk("R8", "scan channel order", chan_log[s0 + k], k % NUM_CH);
        end
        chk("R9", "in-flight result delivered", fires - f0, 6);
        chk("R2", "one dma per scan result", dma_cnt - d0, 6);
        for (int k = 0; k < NUM_CH; k++) begin
            bus_read(1 + k, v);
            chk("R2", "scan result", v, int'(exp_res[k]));
        end
        bus_read(0, v);
        chk("R9", "run low after stop", (v >> 5) & 1, 0);
        bus_write(0, csr(0, 0, 0, 0, 0));
    endtask

    task automatic t_stray();
        int v;
        int d0 = dma_cnt;
        int snap [NUM_CH];
        for (int k = 0; k < NUM_CH; k++) begin
            bus_read(1 + k, v);
            snap[k] = v;
        end
        stray_val = 10'h3A5;
        stray_req++;
        idle(5);
        chk("R11", "no dma on stray pulse", dma_cnt - d0, 0);
        for (int k = 0; k < NUM_CH; k++) begin
            bus_read(1 + k, v);
            chk("R11", "result unchanged by stray pulse", v, snap[k]);
        end
        bus_read(0, v);
        chk("R11", "flag unchanged by stray pulse", (v >> 7) & 1, 0);
    endtask

    task automatic t_standby();
        int v;
        int s0;
        int d0;
        bus_write(0, csr(1, 1, 1, 1, 0));
        wait_fire();
        wait_fire();
        idle(2);
        chk("R3", "irq before standby", int'(irq), 1);
        standby = 1'b1;
        idle(2);
        chk("R10", "irq held low in standby", int'(irq), 0);
        chk("R10", "start held low in standby", int'(conv_start), 0);
        chk("R10", "dma held low in standby", int'(dma_req), 0);
        idle(1);
        standby = 1'b0;
        bus_read(0, v);
        chk("R10", "control word after standby", v, 0);
        for (int k = 0; k < NUM_CH; k++) begin
            bus_read(1 + k, v);
            chk("R10", "result after standby", v, 0);
        end
        s0 = starts;
        d0 = dma_cnt;
        idle(30);
        chk("R10", "no restart after standby", starts - s0, 0);
        chk("R10", "no dma after standby", dma_cnt - d0, 0);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        standby   = 1'b0;
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_single();
        t_no_read_clear();
        t_race();
        t_priority();
        t_scan();
        t_stray();
        t_standby();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule